// File: doc/BRIEF.md
# EEPROM Station-Address Autoload Sequencer

This block runs once after reset, and again on request. It fetches the configuration area of a serial EEPROM through a simple word-read port and derives the 48-bit station address from it. The read port is the request side of a separate serial-EEPROM master. The sequencer holds a request with a word address and an address-width select, and the master answers each request with a one-cycle acknowledge that carries a 16-bit word.

Serial EEPROMs come with either 6-bit or 8-bit word addresses. The sequencer first reads word 0 using the narrow form. An answer of all ones means the part needs the wide form. It then reads words 0 to 63 in order, adds them modulo 2^16, and compares the sum with the signature 0xBABA. The first three words supply the station address. Downstream logic sees the address only after the check passes. Otherwise it sees zero, together with a checksum-error flag. If a read never completes, a timeout ends the sequence early.

Top module: `eeld_autoload`

## Requirements
- R1: After reset is released, and after any start pulse, the first request reads word 0 with `ee_wide_o` = 0, which selects narrow 6-bit addressing.
- R2: If that probe word reads 0xFFFF, every later request uses `ee_wide_o` = 1. Any other value gives `ee_wide_o` = 0.
- R3: After the probe, exactly 64 reads follow, at addresses 0, 1, ... 63 in increasing order. `ee_req_o` stays high until `ee_ack_i`, and the address advances at the acknowledging edge.
- R4: The 64 words are summed modulo 2^16. A sum of 0xBABA gives `mac_valid_o` = 1 and `csum_err_o` = 0.
- R5: Byte order of the station address. `mac_o[47:40]` = word0[7:0], `[39:32]` = word0[15:8], `[31:24]` = word1[7:0], `[23:16]` = word1[15:8], `[15:8]` = word2[7:0] and `[7:0]` = word2[15:8].
- R6: Any other sum gives `csum_err_o` = 1, `mac_valid_o` = 0 and `mac_o` = 0.
- R7: If a request sees no acknowledge for TMO_CYCLES cycles, the sequence ends. The request drops, `timeout_o` = 1, `done_o` = 1, `mac_o` = 0, and `mac_valid_o` and `csum_err_o` both stay 0.
- R8: `done_o` rises only after the 65th acknowledge (probe plus 64 words), or on a timeout. It then holds until the next start, and no request is made while it is high.
- R9: A one-cycle `start_i` in any state takes effect at the next edge. It clears `done_o`, `mac_valid_o`, `csum_err_o`, `timeout_o`, `mac_o` and the sum, and the sequence begins again with the probe.
- R10: `mac_o` reads zero whenever `mac_valid_o` is low, including during a scan whose first three words have already been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle restart pulse |
| ee_req_o | output | 1 | Word-read request, held until acknowledged |
| ee_addr_o | output | 8 | Word address of the pending read |
| ee_wide_o | output | 1 | 1 = 8-bit address form, 0 = 6-bit form |
| ee_ack_i | input | 1 | One-cycle completion of the pending read |
| ee_data_i | input | 16 | Word returned with the acknowledge |
| mac_o | output | 48 | Station address, zero unless valid |
| mac_valid_o | output | 1 | Sequence complete with matching checksum |
| csum_err_o | output | 1 | Sequence complete with wrong checksum |
| timeout_o | output | 1 | Sequence aborted by a missing acknowledge |
| done_o | output | 1 | Sequence finished, whether completed or aborted |

## Verification
Some cases are hard to reach from the ports: a timeout that strikes in the middle of the scan, after the address words have already been captured, and a restart that arrives while a scan is in flight. The bench's EEPROM model therefore has an acknowledge budget that it can exhaust at a chosen word, and a restart pulse is timed against the model's own count of served reads. The width probe is driven by a model that answers narrow requests with all ones when it stands for a wide part. Checksum images are built so that the running sum wraps several times, and the final word is solved to land exactly on, or exactly one past, the signature.

// File: rtl/eeld_pkg.sv
// Shared types and constants for the EEPROM autoload sequencer.
// Assumes 16-bit EEPROM words and a 48-bit station address.
package eeld_pkg;
    typedef enum logic [1:0] {
        ST_PROBE = 2'd0,
        ST_SCAN  = 2'd1,
        ST_CHECK = 2'd2,
        ST_DONE  = 2'd3
    } eeld_state_e;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned MAC_W    = 48;
    localparam logic [WORD_W-1:0] ALL_ONES = '1;

    // Put the low byte first, as the station address expects.
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction
endpackage

// File: rtl/eeld_timer.sv
// Acknowledge watchdog: counts the cycles a request has been pending
// and flags the cycle in which the limit is reached without an ack.
// Assumes TMO_CYCLES >= 2.
module eeld_timer #(
    parameter int unsigned TMO_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic req_i,
    input  logic ack_i,
    output logic hit_o
);
    localparam int unsigned TMO_W = $clog2(TMO_CYCLES);
    localparam logic [TMO_W-1:0] LIMIT = TMO_W'(TMO_CYCLES - 1);

    logic [TMO_W-1:0] cnt_q;

    // Count pending cycles, restarting on every ack or idle cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i || !req_i || ack_i)
            cnt_q <= '0;
        else if (cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = req_i && !ack_i && (cnt_q == LIMIT);

    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
endmodule

// File: rtl/eeld_seq.sv
// Read sequencer: probes word 0 in the narrow form, latches the width,
// then walks words 0..WORDS-1, each held until its acknowledge.
// Assumes the EEPROM master pulses ack for one cycle per request.
module eeld_seq
    import eeld_pkg::*;
#(
    parameter int unsigned WORDS  = 64,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              ack_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              tmo_hit_i,
    output logic              req_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              wide_o,
    output logic [$clog2(WORDS)-1:0] idx_o,
    output logic              scan_ack_o,
    output logic              finish_o,
    output logic              abort_o
);
    localparam int unsigned IDX_W = $clog2(WORDS);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    eeld_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             wide_q;

    // Advance through probe, scan and check; restart has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            state_q <= ST_PROBE;
            idx_q   <= '0;
            wide_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_PROBE: begin
                    if (ack_i) begin
                        wide_q  <= (data_i == ALL_ONES);
                        idx_q   <= '0;
                        state_q <= ST_SCAN;
                    end else if (tmo_hit_i) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_SCAN: begin
                    if (ack_i) begin
                        if (idx_q == LAST) state_q <= ST_CHECK;
                        else               idx_q   <= idx_q + 1'b1;
                    end else if (tmo_hit_i) begin
                        state_q <= ST_DONE;
                    end
                end
                ST_CHECK: state_q <= ST_DONE;
                default:  state_q <= ST_DONE;
            endcase
        end
    end

    // Drive the read port from the current state.
    always_comb begin
        req_o  = (state_q == ST_PROBE) || (state_q == ST_SCAN);
        wide_o = (state_q == ST_SCAN) && wide_q;
        addr_o = (state_q == ST_SCAN) ? {{(ADDR_W-IDX_W){1'b0}}, idx_q} : '0;
    end

    assign idx_o      = idx_q;
    assign scan_ack_o = (state_q == ST_SCAN) && ack_i;
    assign finish_o   = (state_q == ST_CHECK);
    assign abort_o    = req_o && tmo_hit_i;

    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && ack_i && !start_i && idx_q != LAST)
            |=> (addr_o == $past(addr_o) + 1'b1));
    a_r3_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !ack_i && !tmo_hit_i && !start_i) |=> (req_o && $stable(addr_o)));
    a_r9_restart_probe: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (req_o && !wide_o && addr_o == '0));
endmodule

// File: rtl/eeld_accum.sv
// Checksum accumulator and station-address capture. Sums every scanned
// word modulo 2^16 and keeps the first MAC_W/16 words byte-swapped.
// Assumes idx_i names the word acknowledged in the same cycle.
module eeld_accum
    import eeld_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              scan_ack_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WORD_W-1:0] data_i,
    output logic [WORD_W-1:0] sum_o,
    output logic [MAC_W-1:0]  shadow_o
);
    localparam int unsigned MAC_WORDS = MAC_W / WORD_W;

    logic [WORD_W-1:0] sum_q;
    logic [WORD_W-1:0] mw_q [MAC_WORDS];

    // Running modulo-2^16 sum of the scanned words.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) sum_q <= '0;
        else if (scan_ack_i)   sum_q <= sum_q + data_i;
    end

    for (genvar k = 0; k < MAC_WORDS; k++) begin : g_mac
        // Capture address word k, low byte first.
        always_ff @(posedge clk) begin
            if (!rst_n || start_i)
                mw_q[k] <= '0;
            else if (scan_ack_i && idx_i == IDX_W'(k))
                mw_q[k] <= swap_bytes(data_i);
        end
        assign shadow_o[MAC_W-1-WORD_W*k -: WORD_W] = mw_q[k];
    end

    assign sum_o = sum_q;

    a_r9_sum_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (sum_o == '0));
endmodule

// File: rtl/eeld_autoload.sv
// EEPROM station-address autoload: probes the address width, scans the
// configuration words, verifies the checksum signature and publishes
// the station address only on a match.
// Assumes a word-read master with a held request and one-cycle ack.
module eeld_autoload
    import eeld_pkg::*;
#(
    parameter int unsigned WORDS      = 64,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned TMO_CYCLES = 4096,
    parameter logic [15:0] SIGNATURE  = 16'hBABA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        ee_req_o,
    output logic [7:0]  ee_addr_o,
    output logic        ee_wide_o,
    input  logic        ee_ack_i,
    input  logic [15:0] ee_data_i,
    output logic [47:0] mac_o,
    output logic        mac_valid_o,
    output logic        csum_err_o,
    output logic        timeout_o,
    output logic        done_o
);
    localparam int unsigned IDX_W = $clog2(WORDS);

    logic              tmo_hit, scan_ack, finish, abort;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] sum;
    logic [MAC_W-1:0]  shadow;
    logic [ADDR_W-1:0] addr;

    eeld_timer #(.TMO_CYCLES(TMO_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_i(ee_req_o), .ack_i(ee_ack_i), .hit_o(tmo_hit)
    );

    eeld_seq #(.WORDS(WORDS), .ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ack_i(ee_ack_i), .data_i(ee_data_i), .tmo_hit_i(tmo_hit),
        .req_o(ee_req_o), .addr_o(addr), .wide_o(ee_wide_o),
        .idx_o(idx), .scan_ack_o(scan_ack), .finish_o(finish), .abort_o(abort)
    );

    eeld_accum #(.IDX_W(IDX_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .scan_ack_i(scan_ack), .idx_i(idx), .data_i(ee_data_i),
        .sum_o(sum), .shadow_o(shadow)
    );

    assign ee_addr_o = 8'(addr);

    // Result registers: set once at check or abort, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            done_o      <= 1'b0;
            mac_valid_o <= 1'b0;
            csum_err_o  <= 1'b0;
            timeout_o   <= 1'b0;
            mac_o       <= '0;
        end else if (finish) begin
            done_o <= 1'b1;
            if (sum == SIGNATURE) begin
                mac_valid_o <= 1'b1;
                mac_o       <= shadow;
            end else begin
                csum_err_o <= 1'b1;
            end
        end else if (abort) begin
            done_o    <= 1'b1;
            timeout_o <= 1'b1;
        end
    end

    a_r4_valid_clean: assert property (@(posedge clk) disable iff (!rst_n)
        mac_valid_o |-> (done_o && !csum_err_o && !timeout_o));
    a_r6_err_zero_mac: assert property (@(posedge clk) disable iff (!rst_n)
        csum_err_o |-> (mac_o == '0 && !mac_valid_o));
    a_r7_timeout_result: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (done_o && !mac_valid_o && !csum_err_o && mac_o == '0));
    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);
    a_r8_no_req_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !ee_req_o);
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !mac_valid_o && !csum_err_o && !timeout_o));
    a_r10_mac_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_valid_o |-> (mac_o == '0));
endmodule

// File: tb/eeld_autoload_tb.sv
module eeld_autoload_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TMO        = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ee_req, ee_wide, ee_ack = 1'b0;
    logic [7:0]  ee_addr;
    logic [15:0] ee_data = '0;
    logic [47:0] mac;
    logic        mac_valid, csum_err, timeout, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeld_autoload #(.TMO_CYCLES(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .ee_req_o(ee_req), .ee_addr_o(ee_addr), .ee_wide_o(ee_wide),
        .ee_ack_i(ee_ack), .ee_data_i(ee_data),
        .mac_o(mac), .mac_valid_o(mac_valid), .csum_err_o(csum_err),
        .timeout_o(timeout), .done_o(done)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] mem [64];
    logic dev_wide = 1'b0;
    int   lat = 1, rcnt = 0, nlog = 0, ack_limit = 1000;
    logic resp_en = 1'b0;
    logic [7:0] log_addr [80];
    logic       log_wide [80];
    logic [31:0] lcg;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // EEPROM model: answers after lat pending cycles, one-cycle ack.
    always @(negedge clk) begin
        if (ee_ack) ee_ack = 1'b0;
        else if (ee_req && resp_en && nlog < ack_limit) begin
            rcnt++;
            if (rcnt >= lat) begin
                rcnt = 0;
                if (dev_wide && !ee_wide)      ee_data = 16'hFFFF;
                else if (!dev_wide && ee_wide) ee_data = 16'h1234;
                else                           ee_data = mem[ee_addr[5:0]];
                if (nlog < 80) begin
                    log_addr[nlog] = ee_addr;
                    log_wide[nlog] = ee_wide;
                end
                nlog++;
                ee_ack = 1'b1;
            end
        end
    end

    function automatic logic [47:0] exp_mac();
        return {mem[0][7:0], mem[0][15:8], mem[1][7:0], mem[1][15:8], mem[2][7:0], mem[2][15:8]};
    endfunction

    // Fill an image; good => sum hits 0xBABA, else one past it.
    task automatic build(input int seed, input logic good);
        logic [15:0] s;
        s = '0;
        lcg = 32'(seed) * 32'd2654435761 + 32'd7;
        for (int i = 0; i < 63; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            mem[i] = lcg[23:8] | 16'h8000;
            if (i == 0 && mem[i] == 16'hFFFF) mem[i] = 16'hFFFE;
            s = s + mem[i];
        end
        mem[63] = 16'hBABA - s + (good ? 16'h0 : 16'h1);
    endtask

    task automatic pulse_start();
        resp_en = 1'b0;
        repeat (3) @(negedge clk);
        nlog = 0; rcnt = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        resp_en = 1'b1;
    endtask

    task automatic wait_done(output int seen_at);
        seen_at = -1;
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (done) begin seen_at = nlog; break; end
        end
    endtask

    task automatic check_run(input logic good, input string tag);
        int at;
        int bad_addr;
        wait_done(at);
        chk(at == 65, {tag, " R8 done after 65 acks"}, 64'(at), 64'd65);
        chk(log_addr[0] == 8'd0 && log_wide[0] == 1'b0, {tag, " R1 probe narrow word0"},
            {log_addr[0], 7'd0, log_wide[0]}, 64'd0);
        bad_addr = 0;
        for (int i = 0; i < 64; i++)
            if (log_addr[i+1] != 8'(i) || log_wide[i+1] != dev_wide) bad_addr++;
        chk(bad_addr == 0, {tag, " R2 R3 scan order and width"}, 64'(bad_addr), 64'd0);
        if (good) begin
            chk(mac_valid && !csum_err && !timeout, {tag, " R4 valid flags"},
                {mac_valid, csum_err, timeout}, 64'b100);
            chk(mac == exp_mac(), {tag, " R5 mac byte order"}, 64'(mac), 64'(exp_mac()));
        end else begin
            chk(!mac_valid && csum_err && mac == '0, {tag, " R6 bad sum zero mac"},
                64'(mac), 64'd0);
        end
        repeat (5) @(negedge clk);
        chk(done && !ee_req, {tag, " R8 done held no req"}, {done, ee_req}, 64'b10);
    endtask

    initial begin
        logic ok_sweep;
        build(100, 1'b1);
        dev_wide = 1'b0; lat = 1;
        repeat (3) @(negedge clk);
        chk(!done && !mac_valid && !csum_err && !timeout && mac == '0,
            "R9 reset state", {done, mac_valid, csum_err, timeout}, 64'd0);
        chk(ee_addr == 8'd0 && !ee_wide, "R1 reset probe address", {ee_addr, ee_wide}, 64'd0);
        rst_n = 1'b1;
        resp_en = 1'b1;
        check_run(1'b1, "reset-run");

        // Near-exhaustive sweep of width, checksum outcome and latency.
        for (int s = 1; s <= 12; s++) begin
            dev_wide = s[0];
            lat = 1 + (s % 3);
            build(s, (s % 3) != 0);
            pulse_start();
            check_run((s % 3) != 0, $sformatf("sweep%0d", s));
        end

        // R7: no answer to the probe at all.
        pulse_start();
        resp_en = 1'b0;
        repeat (TMO + 8) @(negedge clk);
        chk(timeout && done && !mac_valid && !csum_err && !ee_req, "R7 probe timeout flags",
            {timeout, done, mac_valid, csum_err, ee_req}, 64'b11000);

        // R7 R10: acks stop mid-scan after the address words were read.
        dev_wide = 1'b0; lat = 1; build(55, 1'b1);
        ack_limit = 10;
        pulse_start();
        repeat (30) @(negedge clk);
        chk(!mac_valid && mac == '0 && !done, "R10 mac zero mid-scan", 64'(mac), 64'd0);
        repeat (TMO + 8) @(negedge clk);
        chk(timeout && done && mac == '0 && !mac_valid, "R7 mid-scan timeout",
            64'(mac), 64'd0);
        ack_limit = 1000;

        // R9: restart while a scan is in flight, then finish cleanly.
        dev_wide = 1'b1; lat = 2; build(77, 1'b1);
        pulse_start();
        while (nlog < 20) @(negedge clk);
        resp_en = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(!done && ee_req && ee_addr == 8'd0 && !ee_wide, "R9 restart returns to probe",
            {done, ee_req, ee_addr, ee_wide}, {1'b0, 1'b1, 8'd0, 1'b0});
        repeat (2) @(negedge clk);
        nlog = 0; rcnt = 0;
        resp_en = 1'b1;
        check_run(1'b1, "restart");

        // R9: restart after a failed run clears the error.
        ok_sweep = 1'b1;
        build(9, 1'b0); dev_wide = 1'b0;
        pulse_start();
        check_run(1'b0, "bad-then-start");
        start_i = 1'b1; @(negedge clk); start_i = 1'b0;
        chk(!csum_err && !done && mac == '0 && ok_sweep, "R9 error cleared by start",
            {csum_err, done}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule